// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (1 KiB)

This block is a slave on a two-wire serial bus. It behaves like a 1024-byte by 8-bit serial EEPROM, with the storage held in an on-chip register array. The clock and data lines come from an open-drain bus. The block synchronises both lines to the system clock and detects edges on the oversampled copies. From those edges it finds start and stop conditions, decodes the device byte and takes in or hands out data bytes. Whenever it acknowledges a byte or sends a zero bit, it pulls the data line low through an output enable.

A host can write in two ways: a single byte, or a page burst of up to sixteen bytes. Both are collected in a page buffer and written to the array only when the stop condition arrives. A host can read in three ways: from the current address, from a random address (a dummy write of the word address followed by a repeated start), or as a sequential stream. One strap input takes part in the device address match. Two bits of the device byte select one of four 256-byte blocks. A protect input suppresses every array write but leaves reads working.

Top module: `seeprom_slave`

## Requirements
- R1: The array holds 1024 bytes. A byte written to any address reads back unchanged.
- R2: The data-line drive enable `sda_oe` changes only while the clock line is low, except when it is released by a start or stop condition.
- R3: A start condition (data falls while clock is high) aborts any transfer in progress, including one in the middle of a byte, and begins a new device byte.
- R4: A stop condition (data rises while clock is high) ends the transfer and releases the data line. Buffered write data reaches the array only at a stop. A repeated start before the stop discards that data.
- R5: After a matching device byte, and after every received word-address or data byte, the slave pulls the data line low for the whole ninth clock high phase. A device byte that does not match gets no acknowledge, and the slave ignores the bus until the next start.
- R6: The device byte, sent MSB first, is: bits 7..4 = 1010, bit 3 = strap value, bits 2..1 = block select, bit 0 = 1 for read and 0 for write. The memory address is {block select, word address}.
- R7: While `wp_i` is high, no array location changes. Reads still return the stored data.
- R8: A page write accepts up to 16 data bytes. Address bits 3..0 wrap within the 16-byte page, and bits 9..4 do not change.
- R9: A current-address read returns the byte that follows the last byte read or written.
- R10: In a sequential read the address advances after each byte and wraps from 1023 to 0.
- R11: When the master does not acknowledge a read byte, the slave stops driving and keeps the data line released until the next start. The data line is also released after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| strap_i | input | 1 | Address strap compared against device byte bit 3 |
| wp_i | input | 1 | Write protect; high blocks all array writes |
| sda_oe | output | 1 | Pull data line low when high |

## Verification
The bench writes a page starting at offset 8, so the burst has to wrap back to the page start. A design that carried the overflow into bit 4 would spill the bytes into the next page, and the sequential read-back would show it. A sequential read across address 1023 checks that the counter wraps to 0 and does not stick or run into a missing block. Other tests drop a write by issuing a repeated start before the stop, send a start in the middle of a byte, write under protect, and send a device byte with the wrong strap. Each of these catches a design that commits early, loses framing, writes despite protect, or acknowledges bytes meant for another device. After a master not-acknowledge, an extra clock pulse must read back high; a design that kept driving would show up there.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WORD,
    S_WR,
    S_RD,
    S_MACK
  } bus_st_e;
endpackage

// File: rtl/seeprom_line_sync.sv
module seeprom_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/seeprom_page_buf.sv
module seeprom_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 10,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BASE_W    = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    base_ld,
  input  logic [BASE_W-1:0]       base_in,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [7:0]              wr_data,
  output logic [BASE_W-1:0]       base_o,
  output logic [PAGE_BYTES-1:0]   valid_o,
  output logic [PAGE_BYTES*8-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_o <= '0;
    else if (base_ld) base_o <= base_in;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic       hit;
    logic       v_q;
    logic [7:0] d_q;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (hit) d_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (clr) v_q <= 1'b0;
      else if (hit) v_q <= 1'b1;
    end

    assign valid_o[g]        = v_q;
    assign data_o[g*8 +: 8]  = d_q;
  end
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int PAGE_BYTES = 16,
  parameter int ADDR_W     = 10,
  localparam int DEPTH     = 1 << ADDR_W,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BASE_W    = ADDR_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    commit,
  input  logic [BASE_W-1:0]       base,
  input  logic [PAGE_BYTES-1:0]   valid,
  input  logic [PAGE_BYTES*8-1:0] data,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [7:0]              rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (valid[i]) mem[{base, IDX_W'(i)}] <= data[i*8 +: 8];
      end
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seeprom_slave.sv
module seeprom_slave
  import seeprom_pkg::*;
#(
  parameter int         BLK_W       = 2,
  parameter int         PAGE_BYTES  = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic strap_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int ADDR_W = BLK_W + 8;
  localparam int IDX_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - IDX_W;

  logic [1:0] rst_pipe;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  seeprom_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  bus_st_e           st, st_d;
  logic [3:0]        bcnt, bcnt_d;
  logic [7:0]        sh, sh_d;
  logic              oe, oe_d, ack_ph, ack_d, rw, rw_d;
  logic [BLK_W-1:0]  blk, blk_d;
  logic [ADDR_W-1:0] addr, addr_d, word_addr;
  logic              pb_base_ld, pb_wr, commit;
  logic [BASE_W-1:0]       pb_base;
  logic [PAGE_BYTES-1:0]   pb_valid;
  logic [PAGE_BYTES*8-1:0] pb_data;
  logic [7:0]        rdata;

  assign word_addr = {blk, sh};
  assign commit    = stop_det && !wp_i && (|pb_valid);

  seeprom_page_buf #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_pbuf (
    .clk(clk), .rst_n(rst_core_n), .clr(start_det | stop_det),
    .base_ld(pb_base_ld), .base_in(word_addr[ADDR_W-1:IDX_W]),
    .wr_en(pb_wr), .wr_idx(addr[IDX_W-1:0]), .wr_data(sh),
    .base_o(pb_base), .valid_o(pb_valid), .data_o(pb_data)
  );

  seeprom_array #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .commit(commit), .base(pb_base), .valid(pb_valid),
    .data(pb_data), .raddr(addr), .rdata(rdata)
  );

  always_comb begin
    st_d = st; bcnt_d = bcnt; sh_d = sh; oe_d = oe; ack_d = ack_ph;
    rw_d = rw; blk_d = blk; addr_d = addr; pb_base_ld = 1'b0; pb_wr = 1'b0;
    if (start_det) begin
      st_d = S_DEV; bcnt_d = 4'd0; ack_d = 1'b0; oe_d = 1'b0;
    end else if (stop_det) begin
      st_d = S_IDLE; bcnt_d = 4'd0; ack_d = 1'b0; oe_d = 1'b0;
    end else begin
      case (st)
        S_DEV, S_WORD, S_WR: begin
          if (scl_rise && !ack_ph && bcnt != 4'd8) begin
            sh_d   = {sh[6:0], sda_s};
            bcnt_d = bcnt + 4'd1;
          end else if (scl_fall && ack_ph) begin
            ack_d = 1'b0; oe_d = 1'b0; bcnt_d = 4'd0;
            if (st == S_DEV) begin
              if (rw) begin
                st_d = S_RD; sh_d = rdata; oe_d = !rdata[7];
              end else begin
                st_d = S_WORD;
              end
            end else begin
              st_d = S_WR;
            end
          end else if (scl_fall && bcnt == 4'd8) begin
            ack_d = 1'b1; oe_d = 1'b1;
            if (st == S_DEV) begin
              if (sh[7:4] == DEV_ID && sh[3] == strap_i) begin
                rw_d  = sh[0];
                blk_d = sh[BLK_W:1];
              end else begin
                ack_d = 1'b0; oe_d = 1'b0; st_d = S_IDLE;
              end
            end else if (st == S_WORD) begin
              addr_d     = word_addr;
              pb_base_ld = 1'b1;
            end else begin
              pb_wr  = 1'b1;
              addr_d = {addr[ADDR_W-1:IDX_W], IDX_W'(addr[IDX_W-1:0] + 1'b1)};
            end
          end
        end
        S_RD: begin
          if (scl_rise && bcnt != 4'd8) begin
            bcnt_d = bcnt + 4'd1;
          end else if (scl_fall && bcnt == 4'd8) begin
            oe_d = 1'b0; st_d = S_MACK; bcnt_d = 4'd0;
            addr_d = addr + 1'b1;
          end else if (scl_fall && bcnt != 4'd0) begin
            sh_d = {sh[6:0], 1'b0};
            oe_d = !sh[6];
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_s) st_d = S_IDLE;
            else       bcnt_d = 4'd1;
          end else if (scl_fall && bcnt == 4'd1) begin
            st_d = S_RD; bcnt_d = 4'd0; sh_d = rdata; oe_d = !rdata[7];
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st <= S_IDLE; bcnt <= '0; sh <= '0; oe <= 1'b0; ack_ph <= 1'b0;
      rw <= 1'b0; blk <= '0; addr <= '0;
    end else begin
      st <= st_d; bcnt <= bcnt_d; sh <= sh_d; oe <= oe_d; ack_ph <= ack_d;
      rw <= rw_d; blk <= blk_d; addr <= addr_d;
    end
  end

  assign sda_oe = oe;
endmodule

// File: rtl/seeprom_slave_chk.sv
module seeprom_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic commit,
  input logic wp_i,
  input logic sda_oe
);
  assert_release_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_release_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_drive_change_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  assert_no_write_protected_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !wp_i);

  assert_commit_only_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> stop_det);
endmodule

bind seeprom_slave seeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .commit(commit), .wp_i(wp_i), .sda_oe(sda_oe)
);

// File: tb/sim_seeprom_slave.sv
module sim_seeprom_slave;
  localparam int Q = 8;

  logic clk, rst_n, scl, msda, strap, wp;
  logic sda_oe, sda_bus;
  int   total = 0, bad = 0, r2_bad = 0;
  logic oe_prev = 1'b0;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic ack_all;

  assign sda_bus = msda & ~sda_oe;

  seeprom_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .wp_i(wp), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) r2_bad++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic b_start();
    msda = 1'b1; qw(); scl = 1'b1; qw(); msda = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic b_stop();
    msda = 1'b0; qw(); scl = 1'b1; qw(); msda = 1'b1; qw(); qw();
  endtask

  task automatic send_bit(input logic b);
    msda = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    msda = 1'b1; qw(); scl = 1'b1; qw(); b = sda_bus; qw(); scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic ab;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ab);
    ack = !ab;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(!give_ack);
  endtask

  function automatic logic [7:0] devb(input logic [1:0] blk, input logic rd);
    return {4'b1010, strap, blk, rd};
  endfunction

  task automatic write_seq(input logic [9:0] a, input int n);
    logic ak;
    ack_all = 1'b1;
    b_start();
    send_byte(devb(a[9:8], 1'b0), ak); ack_all &= ak;
    send_byte(a[7:0], ak); ack_all &= ak;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); ack_all &= ak;
    end
    b_stop();
    qw();
  endtask

  task automatic read_rand(input logic [9:0] a, input int n);
    logic ak;
    ack_all = 1'b1;
    b_start();
    send_byte(devb(a[9:8], 1'b0), ak); ack_all &= ak;
    send_byte(a[7:0], ak); ack_all &= ak;
    b_start();
    send_byte(devb(a[9:8], 1'b1), ak); ack_all &= ak;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    b_stop();
    qw();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R11 released after reset", sda_oe, 0);
  endtask

  task automatic t_blocks();
    for (int b = 0; b < 4; b++) begin
      wbuf[0] = 8'h10 + 8'(b);
      write_seq({2'(b), 8'hA5}, 1);
      check(ack_all, "R5 acks on byte write", ack_all, 1);
    end
    for (int b = 0; b < 4; b++) begin
      read_rand({2'(b), 8'hA5}, 1);
      check(rbuf[0] == 8'h10 + 8'(b), "R1 R6 block readback", rbuf[0], 8'h10 + b);
    end
  endtask

  task automatic t_mismatch();
    logic ak;
    b_start();
    send_byte({4'b1010, ~strap, 2'b00, 1'b0}, ak);
    b_stop(); qw();
    check(!ak, "R5 wrong strap not acked", ak, 0);
    b_start();
    send_byte({4'b1011, strap, 2'b00, 1'b0}, ak);
    b_stop(); qw();
    check(!ak, "R5 wrong id not acked", ak, 0);
  endtask

  task automatic t_start_abort();
    b_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    read_rand(10'h0A5, 1);
    check(ack_all, "R3 acks after aborted byte", ack_all, 1);
    check(rbuf[0] == 8'h10, "R3 read after abort", rbuf[0], 8'h10);
  endtask

  task automatic t_page();
    for (int i = 0; i < 16; i++) wbuf[i] = 8'h40 + 8'(i);
    write_seq(10'h1F8, 16);
    check(ack_all, "R8 page bytes acked", ack_all, 1);
    read_rand(10'h1F0, 16);
    for (int k = 0; k < 16; k++)
      check(rbuf[k] == 8'h40 + 8'((k + 8) & 15), "R8 page wrap", rbuf[k], 8'h40 + ((k + 8) & 15));
  endtask

  task automatic t_discard();
    logic ak;
    wbuf[0] = 8'h11;
    write_seq(10'h100, 1);
    b_start();
    send_byte(devb(2'b01, 1'b0), ak);
    send_byte(8'h00, ak);
    send_byte(8'h99, ak);
    b_start();
    b_stop(); qw();
    read_rand(10'h100, 1);
    check(rbuf[0] == 8'h11, "R4 no commit without stop", rbuf[0], 8'h11);
  endtask

  task automatic t_wp();
    wbuf[0] = 8'h22;
    write_seq(10'h020, 1);
    wp = 1'b1;
    wbuf[0] = 8'h77;
    write_seq(10'h020, 1);
    read_rand(10'h020, 1);
    check(rbuf[0] == 8'h22, "R7 protected write ignored", rbuf[0], 8'h22);
    wp = 1'b0;
  endtask

  task automatic t_current();
    logic ak;
    wbuf[0] = 8'h11; wbuf[1] = 8'h5C;
    write_seq(10'h1A5, 2);
    read_rand(10'h1A5, 1);
    check(rbuf[0] == 8'h11, "R9 random read", rbuf[0], 8'h11);
    b_start();
    send_byte(devb(2'b00, 1'b1), ak);
    recv_byte(rbuf[0], 1'b0);
    b_stop(); qw();
    check(ak, "R9 current read acked", ak, 1);
    check(rbuf[0] == 8'h5C, "R9 current address read", rbuf[0], 8'h5C);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hE1; write_seq(10'h3FF, 1);
    wbuf[0] = 8'hE2; write_seq(10'h000, 1);
    read_rand(10'h3FF, 2);
    check(rbuf[0] == 8'hE1, "R10 byte at 1023", rbuf[0], 8'hE1);
    check(rbuf[1] == 8'hE2, "R10 wrap to 0", rbuf[1], 8'hE2);
  endtask

  task automatic t_nack();
    logic ak, b;
    int drv;
    wbuf[0] = 8'h00;
    write_seq(10'h2B0, 1);
    b_start();
    send_byte(devb(2'b10, 1'b0), ak);
    send_byte(8'hB0, ak);
    b_start();
    send_byte(devb(2'b10, 1'b1), ak);
    recv_byte(rbuf[0], 1'b0);
    drv = 0;
    fork
      recv_bit(b);
      repeat (4 * Q) begin
        @(negedge clk);
        if (sda_oe) drv++;
      end
    join
    b_stop(); qw();
    check(rbuf[0] == 8'h00, "R11 zero byte read", rbuf[0], 0);
    check(b == 1'b1, "R11 line high after nack", b, 1);
    check(drv == 0, "R11 no drive after nack", drv, 0);
  endtask

  initial begin
    rst_n = 1'b0; scl = 1'b1; msda = 1'b1; strap = 1'b1; wp = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_blocks();
    t_mismatch();
    t_start_abort();
    t_page();
    t_discard();
    t_wp();
    t_current();
    t_wrap();
    t_nack();
    check(r2_bad == 0, "R2 drive changes with clock high", r2_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule